// File: doc/BRIEF.md
# I2C Channel-Select Controller

This block is an I2C target. It holds a control word in which each bit enables one downstream channel. Its registered enable outputs drive external bidirectional pass switches, so a single upstream I2C bus can be fanned out to any subset of the downstream segments.

The block samples the bus lines with the system clock. It filters out short spikes and then recognises START, repeated START and STOP conditions. It answers to a 7-bit address made of a fixed upper nibble and three strap pins. A write stages a new mask, and the outputs only take the new mask when a STOP is seen. Because of this, a segment is never joined to the bus in the middle of a transfer. A read returns the mask that is currently applied. SDA is an open-drain pull-low enable.

Top module: `i2cmux_ctrl`

## Requirements
- R1: The target address is the 7-bit value 4'b1110 followed by strap_i[2:0] (strap_i[2] most significant), giving 0x70 to 0x77. sda_oe is high during the ninth clock of the address byte only when the first seven received bits equal that value.
- R2: The eighth bit of the address byte selects the direction: 0 means the data bytes that follow are written, and 1 means the target sends data.
- R3: After a committed write of byte B, chan_en[n] equals B[n] for every n. Any pattern, including 0x00 and 0xFF, is accepted.
- R4: A written byte does not change chan_en before a STOP. chan_en keeps its previous value until the STOP and changes within a few clocks after it.
- R5: In a write transaction with several data bytes, each byte is acknowledged, and only the last one is applied at STOP.
- R6: A read sends the applied mask MSB first, with sda_oe high for each 0 bit. If the master acknowledges, the same mask is sent again. After a not-acknowledge, SDA is released.
- R7: A repeated START restarts address reception and does not apply the staged byte. A later STOP applies it.
- R8: rst (synchronous, active high) clears chan_en, the staged byte and the pending-write flag, releases SDA and returns the bus logic to idle. A STOP after reset leaves chan_en at 0x00.
- R9: A pulse on scl_i or sda_i shorter than FILT_CYCLES system clocks has no effect on the bus logic.
- R10: sda_oe is high only in acknowledge slots driven by the target and for 0 bits of read data.
- R11: After a non-matching address, no acknowledge is given and the following bytes are ignored until the next START, so chan_en is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| strap_i | input | 3 | Low address bits from strap pins |
| sda_oe | output | 1 | Pull SDA low when high |
| chan_en | output | NCH | Per-channel switch enable |

## Verification
The bench builds the block with FILT_CYCLES=4 and NCH=8. It drives each bus phase for 12 system clocks, so every bus edge settles through the synchronizer and the filter well inside one phase. With these values, a 2-clock spike on SDA while SCL is high, or on SCL during a high phase, is shorter than the filter window. Such a spike would otherwise read as a false START, STOP or extra clock edge. The full 8-bit mask width lets the bench check the all-ones, all-zeros and mixed patterns bit for bit on the outputs.

// File: rtl/i2cmux_pkg.sv
package i2cmux_pkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 3;
  localparam logic [3:0] ADDR_FIXED = 4'b1110;
  localparam int BITC_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/i2cmux_glitch.sv
module i2cmux_glitch #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(STABLE + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == clean_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE - 1)) begin
        clean_o <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: the clean line only ever moves to a value the synchronizer presented
  assert_filter_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (clean_o != $past(clean_o)) |-> ($past(sync_q[1]) == clean_o));
endmodule

// File: rtl/i2cmux_cond.sv
module i2cmux_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_i & scl_q & sda_q & ~sda_i;
    stop_o  = scl_i & scl_q & ~sda_q & sda_i;
    rise_o  = scl_i & ~scl_q;
    fall_o  = ~scl_i & scl_q;
  end
endmodule

// File: rtl/i2cmux_fsm.sv
module i2cmux_fsm
  import i2cmux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 sda_i,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic [BYTE_W-1:0]    rd_byte_i,
  output logic                 sda_oe_o,
  output logic                 commit_o,
  output logic [BYTE_W-1:0]    staged_o
);
  bus_st_e             st_q;
  logic [BITC_W-1:0]   bitc_q;
  logic [BYTE_W-1:0]   sh_q;
  logic                rw_q;
  logic                pend_q;
  logic                mack_q;
  logic                full;

  assign full = (bitc_q == BITC_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      bitc_q   <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      pend_q   <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      commit_o <= 1'b0;
      staged_o <= '0;
    end else begin
      commit_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
        if (pend_q) begin
          commit_o <= 1'b1;
          pend_q   <= 1'b0;
        end
      end else if (start_i) begin
        st_q     <= ST_ADDR;
        bitc_q   <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_WR: begin
            if (rise_i) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_i};
              bitc_q <= bitc_q + 1'b1;
            end else if (fall_i && full) begin
              if (st_q == ST_WR) begin
                staged_o <= sh_q;
                pend_q   <= 1'b1;
                sda_oe_o <= 1'b1;
                st_q     <= ST_WACK;
              end else if (sh_q[BYTE_W-1:1] == {ADDR_FIXED, strap_i}) begin
                rw_q     <= sh_q[0];
                sda_oe_o <= 1'b1;
                st_q     <= ST_AACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (fall_i) begin
              bitc_q <= '0;
              if (rw_q) begin
                sh_q     <= rd_byte_i;
                sda_oe_o <= ~rd_byte_i[BYTE_W-1];
                st_q     <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_WR;
              end
            end
          end
          ST_WACK: begin
            if (fall_i) begin
              sda_oe_o <= 1'b0;
              bitc_q   <= '0;
              st_q     <= ST_WR;
            end
          end
          ST_RD: begin
            if (rise_i) begin
              bitc_q <= bitc_q + 1'b1;
            end else if (fall_i) begin
              if (full) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (rise_i) begin
              mack_q <= ~sda_i;
            end else if (fall_i) begin
              if (mack_q) begin
                sh_q     <= rd_byte_i;
                sda_oe_o <= ~rd_byte_i[BYTE_W-1];
                bitc_q   <= '0;
                st_q     <= ST_RD;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: pull-low only in target-driven slots
  assert_oe_slots_R10: assert property (@(posedge clk) disable iff (rst)
    sda_oe_o |-> (st_q == ST_AACK || st_q == ST_WACK || st_q == ST_RD));

  // R1: an address acknowledge is only held for the own address
  assert_addr_match_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_AACK) |-> (sh_q[BYTE_W-1:1] == {ADDR_FIXED, strap_i}));

  // R5: a staged byte only appears at the end of a written data byte
  assert_stage_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    (staged_o != $past(staged_o)) |-> ($past(st_q) == ST_WR));

  // R11: nothing is driven while idle after an address mismatch
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/i2cmux_ctrl.sv
module i2cmux_ctrl
  import i2cmux_pkg::*;
#(
  parameter int NCH = 8,
  parameter int FILT_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  output logic               sda_oe,
  output logic [NCH-1:0]     chan_en
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic start_w, stop_w, rise_w, fall_w, commit_w;
  logic [BYTE_W-1:0] staged_w, rd_byte;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cmux_glitch #(.STABLE(FILT_CYCLES)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (raw_lines[g]),
      .clean_o (clean_lines[g])
    );
  end

  i2cmux_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (clean_lines[1]),
    .sda_i   (clean_lines[0]),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  i2cmux_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .sda_i     (clean_lines[0]),
    .strap_i   (strap_i),
    .rd_byte_i (rd_byte),
    .sda_oe_o  (sda_oe),
    .commit_o  (commit_w),
    .staged_o  (staged_w)
  );

  always_comb begin
    rd_byte = '0;
    rd_byte[NCH-1:0] = chan_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en <= '0;
    end else if (commit_w) begin
      chan_en <= staged_w[NCH-1:0];
    end
  end

  // R4: channel enables move only on a STOP-driven commit
  assert_chan_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_en) |-> ($past(commit_w) || $past(rst)));

  // R7: a commit is always preceded by a STOP, never by a START
  assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
    commit_w |-> $past(stop_w));
endmodule

// File: tb/i2cmux_ctrl_test.sv
module i2cmux_ctrl_test;
  localparam int Q = 12;
  localparam int NV = 8;
  // {strap[2:0], addr[6:0], data[7:0], exp_ack, exp_chan[7:0]}
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 7'h70, 8'hA5, 1'b1, 8'hA5},
    {3'd0, 7'h71, 8'hFF, 1'b0, 8'hA5},
    {3'd5, 7'h75, 8'h00, 1'b1, 8'h00},
    {3'd5, 7'h70, 8'h3C, 1'b0, 8'h00},
    {3'd7, 7'h77, 8'hFF, 1'b1, 8'hFF},
    {3'd2, 7'h72, 8'h81, 1'b1, 8'h81},
    {3'd2, 7'h7A, 8'h18, 1'b0, 8'h81},
    {3'd2, 7'h32, 8'h42, 1'b0, 8'h81}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_d = 1'b1;
  logic sda_d = 1'b1;
  logic [2:0] strap = 3'd0;
  logic sda_oe;
  logic [7:0] chan_en;
  logic sda_line;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_d & ~sda_oe;

  i2cmux_ctrl #(.NCH(8), .FILT_CYCLES(4)) uut (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_d),
    .sda_i   (sda_line),
    .strap_i (strap),
    .sda_oe  (sda_oe),
    .chan_en (chan_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_d = 1'b0; idle(Q); scl_d = 1'b0; idle(Q);
  endtask

  task automatic do_rstart();
    sda_d = 1'b1; idle(Q); scl_d = 1'b1; idle(Q);
    sda_d = 1'b0; idle(Q); scl_d = 1'b0; idle(Q);
  endtask

  task automatic do_stop();
    sda_d = 1'b0; idle(Q); scl_d = 1'b1; idle(Q); sda_d = 1'b1; idle(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_d = b; idle(Q); scl_d = 1'b1; idle(2 * Q); scl_d = 1'b0; idle(Q);
  endtask

  task automatic get_ack(output logic a);
    sda_d = 1'b1; idle(Q); scl_d = 1'b1; idle(Q);
    a = sda_oe; idle(Q); scl_d = 1'b0; idle(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(a);
  endtask

  task automatic get_byte(input logic ack_it, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sda_d = 1'b1; idle(Q); scl_d = 1'b1; idle(Q);
      v = {v[6:0], sda_line}; idle(Q); scl_d = 1'b0; idle(Q);
    end
    put_bit(ack_it ? 1'b0 : 1'b1);
  endtask

  initial begin
    idle(150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rv;
    idle(4);
    rst = 1'b0;
    idle(Q);
    // R8: reset state
    chk("R8 reset chan_en", 32'(chan_en), 32'h00);
    chk("R8 reset sda_oe", 32'(sda_oe), 32'h0);

    // Table of write/readback transactions (R1 R2 R3 R11)
    for (int k = 0; k < NV; k++) begin
      strap = VEC[k][26:24];
      idle(Q);
      do_start();
      put_byte({VEC[k][23:17], 1'b0}, a);
      chk("R1 address ack", 32'(a), 32'(VEC[k][8]));
      put_byte(VEC[k][16:9], a);
      if (VEC[k][8]) chk("R5 data ack", 32'(a), 32'h1);
      else chk("R11 no ack after mismatch", 32'(a), 32'h0);
      do_stop();
      chk("R3 chan_en after write", 32'(chan_en), 32'(VEC[k][7:0]));
      if (VEC[k][8]) begin
        do_start();
        put_byte({VEC[k][23:17], 1'b1}, a);
        chk("R2 read address ack", 32'(a), 32'h1);
        get_byte(1'b0, rv);
        chk("R6 read value", 32'(rv), 32'(VEC[k][7:0]));
        do_stop();
      end
    end

    // R4 R5: several bytes, staged until STOP
    strap = 3'd3;
    idle(Q);
    do_start();
    put_byte({7'h73, 1'b0}, a);
    chk("R1 strap 3 ack", 32'(a), 32'h1);
    put_byte(8'h11, a);
    chk("R5 first byte ack", 32'(a), 32'h1);
    put_byte(8'h22, a);
    chk("R5 second byte ack", 32'(a), 32'h1);
    chk("R4 chan_en held before stop", 32'(chan_en), 32'h81);
    put_byte(8'h33, a);
    chk("R5 third byte ack", 32'(a), 32'h1);
    idle(4 * Q);
    chk("R4 chan_en held before stop late", 32'(chan_en), 32'h81);
    do_stop();
    chk("R5 last byte applied", 32'(chan_en), 32'h33);

    // R7: repeated START does not commit; read sees old mask twice
    do_start();
    put_byte({7'h73, 1'b0}, a);
    put_byte(8'h5A, a);
    chk("R7 write ack", 32'(a), 32'h1);
    do_rstart();
    put_byte({7'h73, 1'b1}, a);
    chk("R7 read after restart ack", 32'(a), 32'h1);
    chk("R7 not committed on restart", 32'(chan_en), 32'h33);
    get_byte(1'b1, rv);
    chk("R6 first read byte", 32'(rv), 32'h33);
    get_byte(1'b0, rv);
    chk("R6 repeated read byte", 32'(rv), 32'h33);
    chk("R10 released after nack", 32'(sda_oe), 32'h0);
    do_stop();
    chk("R7 stop commits staged", 32'(chan_en), 32'h5A);

    // R9: short spikes on SDA and SCL are rejected
    sda_d = 1'b0; idle(2); sda_d = 1'b1; idle(2 * Q);
    for (int i = 7; i >= 0; i--) put_bit(1'b0);
    get_ack(a);
    chk("R9 idle spike not a start", 32'(a), 32'h0);
    do_stop();
    do_start();
    put_byte({7'h73, 1'b0}, a);
    for (int i = 7; i >= 0; i--) begin
      sda_d = (i >= 4); idle(Q); scl_d = 1'b1; idle(Q);
      if (i == 7) begin sda_d = 1'b0; idle(2); sda_d = 1'b1; end
      if (i == 5) begin scl_d = 1'b0; idle(2); scl_d = 1'b1; end
      if (i == 2) begin sda_d = 1'b1; idle(2); sda_d = 1'b0; end
      idle(Q); scl_d = 1'b0; idle(Q);
    end
    get_ack(a);
    chk("R9 byte ack with spikes", 32'(a), 32'h1);
    do_stop();
    chk("R9 spiked byte intact", 32'(chan_en), 32'hF0);

    // R8: reset in mid-transaction clears outputs and staged data
    do_start();
    put_byte({7'h73, 1'b0}, a);
    put_byte(8'h99, a);
    rst = 1'b1; idle(3); rst = 1'b0; idle(Q);
    chk("R8 chan_en cleared", 32'(chan_en), 32'h00);
    chk("R8 sda released", 32'(sda_oe), 32'h0);
    do_stop();
    chk("R8 stop after reset no commit", 32'(chan_en), 32'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule